// File: doc/BRIEF.md
# Event-to-Task Channel Crossbar

This block lets a hardware event from one peripheral start an action in another peripheral without any processor involvement. Peripherals raise single-cycle pulses on a vector of event inputs. The crossbar holds a fixed number of channels. Each channel picks one event source, one primary task destination and, if wanted, a second "fork" destination. When an enabled channel sees its event, it drives a one-cycle pulse on the chosen task outputs on the next clock.

Configuration comes over a small write-only register bus: a write strobe, an 8-bit address and 32 bits of data. Channels are switched on and off through a set register and a clear register. Software can also define channel groups and switch every member of a group on or off with a single write. The highest-numbered channels are pre-programmed at reset and their routing cannot be overwritten. Their enables and group memberships still work like those of any other channel.

The number of events, tasks, channels, fixed channels and groups are parameters. Indices are 7 bits wide, so up to 128 events and 128 tasks are supported. Up to 32 channels and 16 groups are supported.

Top module: `evtx_crossbar`

## Requirements
- R1: After reset, every channel enable is 0, every group is empty, every writable channel has invalid endpoints, and taskOut is all zeros.
- R2: An enabled channel with a valid event index e and a valid primary index p turns an event[e] pulse in cycle n into taskOut[p] high in cycle n+1 only, for exactly one cycle.
- R3: A channel whose fork endpoint is valid pulses the fork task in the same cycle as its primary task. A channel whose fork valid bit is 0 produces nothing on its fork index.
- R4: A channel whose enable bit is 0 never produces a task pulse, however its endpoints are set.
- R5: A write to address 0x00 sets the enable of every channel whose data bit is 1. Data bits that are 0 leave the matching enables unchanged.
- R6: A write to address 0x01 clears the enable of every channel whose data bit is 1. Data bits that are 0 leave the matching enables unchanged.
- R7: A write to address 0x10+g stores data[NUM_CHANNELS-1:0] as the member mask of group g. A write to 0x02 enables every member of each group whose data bit is 1. A write to 0x03 disables every such member. Writes to groups g >= NUM_GROUPS are ignored.
- R8: Channel NUM_CHANNELS-NUM_FIXED+f (f from 0) is hardwired to route event NUM_EVENTS-1-f to task NUM_TASKS-1-f, with no fork. Configuration writes to such a channel are ignored, but its enable and group membership behave normally.
- R9: When several channels hit the same task in one cycle, that task output is the OR of those hits: a single high bit.
- R10: Channel c is configured by a write to 0x40+c. The data format is: bits [6:0] event index, bit 7 event valid, bits [14:8] primary task index, bit 15 primary valid, bits [22:16] fork index, bit 23 fork valid. An endpoint whose valid bit is 0, or whose index is at or beyond the event or task count, never fires.
- R11: A write changes routing from the following cycle onward. An event in the same cycle as the write is routed with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one write per cycle |
| wrAddr | input | 8 | Register address |
| wrData | input | 32 | Register write data |
| events | input | NUM_EVENTS | Event pulses from peripherals |
| taskOut | output | NUM_TASKS | Registered task pulses to peripherals |

## Verification
The properties assume that reset is applied before any write and that at most one register operation arrives per clock; the bus carries a single address per cycle, so this holds by its shape. They place no limit on how many events are high at once or how long they stay high. The stimulus therefore fires wide, overlapping event patterns, writes in the same cycle as events, and writes to unused and out-of-range addresses and fields. A behavioural model checks every clock, and directed cases cover each requirement.

// File: rtl/evtx_pkg.sv
package evtx_pkg;

  // Width of an endpoint index inside a configuration word
  localparam int IDX_W = 7;

  // Register map
  localparam logic [7:0] ADDR_EN_SET   = 8'h00;
  localparam logic [7:0] ADDR_EN_CLR   = 8'h01;
  localparam logic [7:0] ADDR_GRP_ON   = 8'h02;
  localparam logic [7:0] ADDR_GRP_OFF  = 8'h03;
  localparam logic [3:0] ADDR_GRP_PAGE = 4'h1;   // 0x10..0x1F group masks
  localparam logic [1:0] ADDR_CFG_PAGE = 2'b01;  // 0x40..0x7F channel configs

  // One endpoint: valid flag above a 7-bit index
  typedef struct packed {
    logic             vld;
    logic [IDX_W-1:0] idx;
  } endpt_t;

  // Channel configuration word, low 24 bits of the write data
  typedef struct packed {
    endpt_t forkSel;  // [23:16]
    endpt_t priSel;   // [15:8]
    endpt_t evtSel;   // [7:0]
  } chan_cfg_t;

  // Strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic        setEn;
    logic        clrEn;
    logic        grpOn;
    logic        grpOff;
    logic        grpMaskWr;
    logic        cfgWr;
    logic [5:0]  idx;
    logic [31:0] data;
  } ctrl_cmd_t;

endpackage

// File: rtl/evtx_ctrl.sv
module evtx_ctrl
  import evtx_pkg::*;
#(
  parameter int NUM_CHANNELS = 8,
  parameter int NUM_FIXED    = 2,
  parameter int NUM_GROUPS   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrAddr,
  input  logic [31:0] wrData,
  output ctrl_cmd_t   cmd
);

  localparam int FIRST_FIXED = NUM_CHANNELS - NUM_FIXED;

  // Address decode: turns one bus write into one strobe
  always_comb begin
    cmd      = '0;
    cmd.data = wrData;
    cmd.idx  = wrAddr[5:0];
    if (wrEn) begin
      if (wrAddr == ADDR_EN_SET) begin
        cmd.setEn = 1'b1;
      end else if (wrAddr == ADDR_EN_CLR) begin
        cmd.clrEn = 1'b1;
      end else if (wrAddr == ADDR_GRP_ON) begin
        cmd.grpOn = 1'b1;
      end else if (wrAddr == ADDR_GRP_OFF) begin
        cmd.grpOff = 1'b1;
      end else if (wrAddr[7:4] == ADDR_GRP_PAGE) begin
        cmd.idx = {2'b00, wrAddr[3:0]};
        if (int'(wrAddr[3:0]) < NUM_GROUPS) cmd.grpMaskWr = 1'b1;
      end else if (wrAddr[7:6] == ADDR_CFG_PAGE) begin
        // pre-programmed channels and channels beyond the count are read-only
        if (int'(wrAddr[5:0]) < FIRST_FIXED) cmd.cfgWr = 1'b1;
      end
    end
  end

  // R8: a config write aimed at a hardwired channel must never reach the datapath
  assert_fixed_cfg_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[7:6] == ADDR_CFG_PAGE && int'(wrAddr[5:0]) >= FIRST_FIXED) |-> !cmd.cfgWr);

  // R7: one bus write yields at most one strobe
  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.setEn, cmd.clrEn, cmd.grpOn, cmd.grpOff, cmd.grpMaskWr, cmd.cfgWr}));

endmodule

// File: rtl/evtx_chan_slot.sv
module evtx_chan_slot
  import evtx_pkg::*;
#(
  parameter int NUM_EVENTS = 16,
  parameter int NUM_TASKS  = 16,
  parameter bit IS_FIXED   = 1'b0,
  parameter int FIXED_EVT  = 0,
  parameter int FIXED_TASK = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWr,
  input  chan_cfg_t            cfgData,
  input  logic [NUM_EVENTS-1:0] events,
  input  logic                 chanOn,
  output logic [NUM_TASKS-1:0] taskHit
);

  localparam int PAD_W = 1 << IDX_W;

  // Hardwired channels come out of reset already routed
  localparam chan_cfg_t FIXED_CFG = {1'b0, 7'd0, 1'b1, 7'(FIXED_TASK), 1'b1, 7'(FIXED_EVT)};
  localparam chan_cfg_t RESET_CFG = IS_FIXED ? FIXED_CFG : chan_cfg_t'('0);

  chan_cfg_t        cfgQ;
  logic [PAD_W-1:0] evPad;
  logic             evtFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cfgQ <= RESET_CFG;
    else if (cfgWr && !IS_FIXED) cfgQ <= cfgData;
  end

  // Zero padding makes an out-of-range event index read as never firing
  assign evPad   = PAD_W'(events);
  assign evtFire = chanOn && cfgQ.evtSel.vld && evPad[cfgQ.evtSel.idx];

  // Decode the primary and fork endpoints onto the task vector
  always_comb begin
    for (int t = 0; t < NUM_TASKS; t++) begin
      taskHit[t] = evtFire &&
                   ((cfgQ.priSel.vld  && cfgQ.priSel.idx  == 7'(t)) ||
                    (cfgQ.forkSel.vld && cfgQ.forkSel.idx == 7'(t)));
    end
  end

endmodule

// File: rtl/evtx_datapath.sv
module evtx_datapath
  import evtx_pkg::*;
#(
  parameter int NUM_EVENTS   = 16,
  parameter int NUM_TASKS    = 16,
  parameter int NUM_CHANNELS = 8,
  parameter int NUM_FIXED    = 2,
  parameter int NUM_GROUPS   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_cmd_t             cmd,
  input  logic [NUM_EVENTS-1:0] events,
  output logic [NUM_TASKS-1:0]  taskOut
);

  localparam int FIRST_FIXED = NUM_CHANNELS - NUM_FIXED;

  logic [NUM_CHANNELS-1:0] chEn;
  logic [NUM_CHANNELS-1:0] chEnNext;
  logic [NUM_CHANNELS-1:0] grpMask [NUM_GROUPS];
  logic [NUM_CHANNELS-1:0] grpUnion;
  logic [NUM_CHANNELS-1:0] wrBits;
  logic [NUM_TASKS-1:0]    hits [NUM_CHANNELS];
  logic [NUM_TASKS-1:0]    taskNext;
  logic                    unusedData;

  assign wrBits     = cmd.data[NUM_CHANNELS-1:0];
  assign unusedData = ^cmd.data;

  // Union of the members of every group named in the write data
  always_comb begin
    grpUnion = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (cmd.data[g]) grpUnion |= grpMask[g];
    end
  end

  // Enable update: set, clear, group on, group off
  always_comb begin
    chEnNext = chEn;
    if (cmd.setEn)  chEnNext = chEn | wrBits;
    if (cmd.clrEn)  chEnNext = chEn & ~wrBits;
    if (cmd.grpOn)  chEnNext = chEn | grpUnion;
    if (cmd.grpOff) chEnNext = chEn & ~grpUnion;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chEn <= '0;
    else       chEn <= chEnNext;
  end

  // Group membership masks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_GROUPS; g++) grpMask[g] <= '0;
    end else if (cmd.grpMaskWr) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (cmd.idx == 6'(g)) grpMask[g] <= wrBits;
      end
    end
  end

  // One slot per channel; the top NUM_FIXED slots are hardwired
  for (genvar c = 0; c < NUM_CHANNELS; c++) begin : g_slot
    localparam bit FIX = (c >= FIRST_FIXED);
    evtx_chan_slot #(
      .NUM_EVENTS (NUM_EVENTS),
      .NUM_TASKS  (NUM_TASKS),
      .IS_FIXED   (FIX),
      .FIXED_EVT  (FIX ? NUM_EVENTS - 1 - (c - FIRST_FIXED) : 0),
      .FIXED_TASK (FIX ? NUM_TASKS  - 1 - (c - FIRST_FIXED) : 0)
    ) u_slot (
      .clk     (clk),
      .rstN    (rstN),
      .cfgWr   (cmd.cfgWr && cmd.idx == 6'(c)),
      .cfgData (cmd.data[23:0]),
      .events  (events),
      .chanOn  (chEn[c]),
      .taskHit (hits[c])
    );
  end

  // Merge all channel hits by OR, then register
  always_comb begin
    taskNext = '0;
    for (int c = 0; c < NUM_CHANNELS; c++) taskNext |= hits[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) taskOut <= '0;
    else       taskOut <= taskNext;
  end

  // R2: no event input means no task output one cycle later
  assert_quiet_events_R2: assert property (@(posedge clk) disable iff (!rstN)
    (events == '0) |=> (taskOut == '0));

  // R4: with no channel enabled, nothing fires on the next cycle
  assert_all_off_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    (chEn == '0) |=> (taskOut == '0));

  // R5: every bit written to the set register ends up enabled
  assert_set_takes_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setEn |=> ((chEn & $past(wrBits)) == $past(wrBits)));

  // R6: every bit written to the clear register ends up disabled
  assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrEn |=> ((chEn & $past(wrBits)) == '0));

  // R7: group enable turns on every member of the selected groups
  assert_group_on_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.grpOn |=> ((chEn & $past(grpUnion)) == $past(grpUnion)));

endmodule

// File: rtl/evtx_crossbar.sv
module evtx_crossbar
  import evtx_pkg::*;
#(
  parameter int NUM_EVENTS   = 16,
  parameter int NUM_TASKS    = 16,
  parameter int NUM_CHANNELS = 8,
  parameter int NUM_FIXED    = 2,
  parameter int NUM_GROUPS   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [7:0]            wrAddr,
  input  logic [31:0]           wrData,
  input  logic [NUM_EVENTS-1:0] events,
  output logic [NUM_TASKS-1:0]  taskOut
);

  ctrl_cmd_t cmd;

  evtx_ctrl #(
    .NUM_CHANNELS (NUM_CHANNELS),
    .NUM_FIXED    (NUM_FIXED),
    .NUM_GROUPS   (NUM_GROUPS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cmd    (cmd)
  );

  evtx_datapath #(
    .NUM_EVENTS   (NUM_EVENTS),
    .NUM_TASKS    (NUM_TASKS),
    .NUM_CHANNELS (NUM_CHANNELS),
    .NUM_FIXED    (NUM_FIXED),
    .NUM_GROUPS   (NUM_GROUPS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .events  (events),
    .taskOut (taskOut)
  );

endmodule

// File: tb/evtx_crossbar_tb.sv
module evtx_crossbar_tb;

  localparam int NE = 16;
  localparam int NT = 16;
  localparam int NC = 8;
  localparam int NF = 2;
  localparam int NG = 4;
  localparam int FF = NC - NF;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [7:0]    wrAddr = '0;
  logic [31:0]   wrData = '0;
  logic [NE-1:0] events = '0;
  logic [NT-1:0] taskOut;

  int    errors = 0;
  int    checks = 0;
  string curReq = "R1";

  // Behavioural model state
  bit            mEn  [NC];
  int            mEv  [NC];
  int            mPt  [NC];
  int            mFk  [NC];
  bit            mEvV [NC];
  bit            mPtV [NC];
  bit            mFkV [NC];
  bit [NC-1:0]   mGrp [NG];
  logic [NT-1:0] expTask = '0;

  evtx_crossbar #(
    .NUM_EVENTS(NE), .NUM_TASKS(NT), .NUM_CHANNELS(NC), .NUM_FIXED(NF), .NUM_GROUPS(NG)
  ) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .events(events), .taskOut(taskOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic void modelReset();
    for (int c = 0; c < NC; c++) begin
      mEn[c] = 0;
      if (c >= FF) begin
        mEv[c] = NE - 1 - (c - FF); mEvV[c] = 1;
        mPt[c] = NT - 1 - (c - FF); mPtV[c] = 1;
        mFk[c] = 0;                 mFkV[c] = 0;
      end else begin
        mEv[c] = 0; mEvV[c] = 0; mPt[c] = 0; mPtV[c] = 0; mFk[c] = 0; mFkV[c] = 0;
      end
    end
    for (int g = 0; g < NG; g++) mGrp[g] = '0;
  endfunction

  function automatic void modelWrite(logic [7:0] a, logic [31:0] d);
    if (a == 8'h00) begin
      for (int c = 0; c < NC; c++) if (d[c]) mEn[c] = 1;
    end else if (a == 8'h01) begin
      for (int c = 0; c < NC; c++) if (d[c]) mEn[c] = 0;
    end else if (a == 8'h02 || a == 8'h03) begin
      for (int g = 0; g < NG; g++)
        if (d[g]) for (int c = 0; c < NC; c++) if (mGrp[g][c]) mEn[c] = (a == 8'h02);
    end else if (a[7:4] == 4'h1) begin
      if (int'(a[3:0]) < NG) mGrp[a[3:0]] = d[NC-1:0];
    end else if (a[7:6] == 2'b01) begin
      if (int'(a[5:0]) < FF) begin
        mEv[a[5:0]] = int'(d[6:0]);   mEvV[a[5:0]] = d[7];
        mPt[a[5:0]] = int'(d[14:8]);  mPtV[a[5:0]] = d[15];
        mFk[a[5:0]] = int'(d[22:16]); mFkV[a[5:0]] = d[23];
      end
    end
  endfunction

  // Model steps on each rising edge: route with old state, then apply the write
  always @(posedge clk) begin : modelStep
    logic [NT-1:0] nx;
    if (!rstN) begin
      modelReset();
      expTask = '0;
    end else begin
      nx = '0;
      for (int c = 0; c < NC; c++) begin
        if (mEn[c] && mEvV[c] && mEv[c] < NE && events[mEv[c]]) begin
          if (mPtV[c] && mPt[c] < NT) nx[mPt[c]] = 1'b1;
          if (mFkV[c] && mFk[c] < NT) nx[mFk[c]] = 1'b1;
        end
      end
      if (wrEn) modelWrite(wrAddr, wrData);
      expTask = nx;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    checks++;
    if (taskOut !== expTask) begin
      errors++;
      $display("FAIL %s per-cycle compare: actual=%h expected=%h", curReq, taskOut, expTask);
    end
  end

  function automatic logic [31:0] cfgWord(bit ev, int e, bit pv, int p, bit fv, int f);
    return {8'h00, fv, 7'(f), pv, 7'(p), ev, 7'(e)};
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic fire(logic [NE-1:0] ev);
    @(negedge clk);
    events = ev;
    @(negedge clk);
    events = '0;
  endtask

  task automatic chk(string req, logic [NT-1:0] exp);
    checks++;
    if (taskOut !== exp) begin
      errors++;
      $display("FAIL %s directed: actual=%h expected=%h", req, taskOut, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state; all groups on must still leave everything silent
    curReq = "R1";
    chk("R1", '0);
    fire('1);           chk("R1", '0);
    wr(8'h02, 32'hF);
    fire('1);           chk("R1", '0);

    // R2: basic routing, one-cycle pulse
    curReq = "R2";
    wr(8'h40, cfgWord(1, 3, 1, 5, 0, 0));
    wr(8'h00, 32'h1);
    fire(16'h0008);     chk("R2", 16'h0020);
    @(negedge clk);     chk("R2", 16'h0000);

    // R3: fork fires with primary; invalid fork gives nothing
    curReq = "R3";
    wr(8'h41, cfgWord(1, 4, 1, 6, 1, 7));
    wr(8'h00, 32'h2);
    fire(16'h0010);     chk("R3", 16'h00C0);
    wr(8'h42, cfgWord(1, 5, 1, 8, 0, 9));
    wr(8'h00, 32'h4);
    fire(16'h0020);     chk("R3", 16'h0100);

    // R4: configured but not enabled
    curReq = "R4";
    wr(8'h43, cfgWord(1, 6, 1, 10, 0, 0));
    fire(16'h0040);     chk("R4", 16'h0000);

    // R5: set register, zeros have no effect
    curReq = "R5";
    wr(8'h00, 32'h0);
    fire(16'h0008);     chk("R5", 16'h0020);
    fire(16'h0040);     chk("R5", 16'h0000);
    wr(8'h00, 32'h8);
    fire(16'h0040);     chk("R5", 16'h0400);

    // R6: clear register, zeros have no effect
    curReq = "R6";
    wr(8'h01, 32'h0);
    fire(16'h0008);     chk("R6", 16'h0020);
    wr(8'h01, 32'h1);
    fire(16'h0008);     chk("R6", 16'h0000);

    // R7: group of channels 1 and 2
    curReq = "R7";
    wr(8'h10, 32'h06);
    wr(8'h01, 32'h06);
    fire(16'h0030);     chk("R7", 16'h0000);
    wr(8'h02, 32'h1);
    fire(16'h0030);     chk("R7", 16'h01C0);
    wr(8'h03, 32'h1);
    fire(16'h0070);     chk("R7", 16'h0400);
    wr(8'h14, 32'hFF);  // group 4 does not exist
    wr(8'h02, 32'h10);
    fire(16'h0030);     chk("R7", 16'h0000);

    // R8: hardwired channels
    curReq = "R8";
    wr(8'h00, 32'h40);
    fire(16'h8000);     chk("R8", 16'h8000);
    wr(8'h46, cfgWord(1, 0, 1, 0, 0, 0));
    fire(16'h0001);     chk("R8", 16'h0000);
    fire(16'h8000);     chk("R8", 16'h8000);
    fire(16'h4000);     chk("R8", 16'h0000);
    wr(8'h00, 32'h80);
    fire(16'h4000);     chk("R8", 16'h4000);

    // R9: two channels into task 5 merge into one bit
    curReq = "R9";
    wr(8'h44, cfgWord(1, 7, 1, 5, 0, 0));
    wr(8'h00, 32'h11);
    fire(16'h0088);     chk("R9", 16'h0020);

    // R10: invalid and out-of-range endpoints
    curReq = "R10";
    wr(8'h45, cfgWord(0, 8, 1, 11, 0, 0));
    wr(8'h00, 32'h20);
    fire(16'h0100);     chk("R10", 16'h0000);
    wr(8'h45, cfgWord(1, 8, 1, 20, 1, 11));
    fire(16'h0100);     chk("R10", 16'h0800);
    wr(8'h45, cfgWord(1, 30, 1, 11, 0, 0));
    fire(16'h0100);     chk("R10", 16'h0000);

    // R11: event in the write's own cycle sees the old routing
    curReq = "R11";
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'h45; wrData = cfgWord(1, 8, 1, 12, 0, 0);
    events = 16'h0100;
    @(negedge clk);
    wrEn = 1'b0; events = '0;
    chk("R11", 16'h0000);
    fire(16'h0100);     chk("R11", 16'h1000);

    // Mixed random traffic checked against the model every cycle
    curReq = "R2";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wrEn = ($urandom % 4) == 0;
      case ($urandom % 8)
        0: begin wrAddr = 8'h00; wrData = $urandom; end
        1: begin wrAddr = 8'h01; wrData = $urandom; end
        2: begin wrAddr = 8'h02; wrData = $urandom; end
        3: begin wrAddr = 8'h03; wrData = $urandom; end
        4: begin wrAddr = 8'h10 + 8'($urandom % 5); wrData = $urandom; end
        5, 6: begin
          wrAddr = 8'h40 + 8'($urandom % 9);
          wrData = cfgWord($urandom % 4 != 0, $urandom % 18, $urandom % 4 != 0,
                           $urandom % 18, $urandom % 2, $urandom % 18);
        end
        default: begin wrAddr = 8'($urandom); wrData = $urandom; end
      endcase
      events = NE'($urandom & $urandom);
    end
    @(negedge clk);
    wrEn = 1'b0; events = '0;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule